// File: doc/BRIEF.md
# Two-wire serial memory write front end

This block is the bus-facing half of a serial memory slave on a two-wire bus. It passes the raw clock and data lines through synchronizers and finds START and STOP conditions. It then shifts in the control byte and checks it against the device code and chip-select value set on its configuration inputs. After a matching write command it collects a two-byte word address and a stream of data bytes. It acknowledges each byte it accepts by pulling the data line low through an open-drain enable.

The block passes the assembled word address, each data byte and the closing STOP event to a separate page-buffer engine as one-cycle pulses. That engine reports a running internal write cycle on `wr_busy`. While `wr_busy` is high, the block does not acknowledge a control byte, so a bus master can poll for the end of the write by repeating the command until it is acknowledged. Write protection belongs to the engine. This block only samples the protect input at STOP and hands it over with the commit event, and protection never changes how the block acknowledges.

Top module: `i2c_mem_write_slave`

## Requirements
- R1: `scl_in` and `sda_in` each pass through two synchronizing flops. A START is a falling edge of synchronized SDA while synchronized SCL is high. A STOP is a rising edge of synchronized SDA while synchronized SCL is high.
- R2: The first byte after START is the control byte, sent MSB first. Bits 7:4 must equal `dev_code`, bits 3:1 must equal `chip_sel`, and bit 0 (R/W) must be 0. Only then is the byte acknowledged. Any other control byte gets no acknowledge, and every byte after it is ignored (no acknowledge, no pulse) until the next START.
- R3: For an accepted byte, `sda_oe` rises only while SCL is low after the eighth SCL clock. It stays high through the ninth SCL clock and drops after the ninth falling edge. At any other time `sda_oe` is low.
- R4: After an accepted control byte, the next two bytes are the high and then the low word address byte, and both are acknowledged. The address is 15 bits and bit 7 of the high byte is ignored. After the low byte, `addr_load` pulses for one cycle with `addr_out` = {high[6:0], low}.
- R5: Every byte after the two address bytes is a data byte. It is acknowledged, and `data_valid` pulses for one cycle with the byte on `data_out`.
- R6: A STOP that follows at least one data byte of the current command gives a single one-cycle `commit` pulse. A STOP before any data byte gives no `commit`.
- R7: While `wr_busy` is high when the control byte completes, the control byte is not acknowledged and the rest of that command is ignored.
- R8: `commit_wp` carries the value of `wp_in` sampled at the STOP that produces `commit`. Acknowledges do not depend on `wp_in`.
- R9: A repeated START or a STOP at any point puts the block back to waiting for a control byte. A repeated START also clears any data seen so far, so a later STOP commits only if data follows the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (resolved level) |
| dev_code | input | 4 | Expected device code |
| chip_sel | input | 3 | Expected chip-select value |
| wr_busy | input | 1 | Internal write cycle running in the engine |
| wp_in | input | 1 | Write-protect level, sampled at STOP |
| sda_oe | output | 1 | Pull data line low (acknowledge) |
| addr_load | output | 1 | One-cycle pulse: word address complete |
| addr_out | output | 15 | Word address |
| data_valid | output | 1 | One-cycle pulse: data byte complete |
| data_out | output | 8 | Received data byte |
| commit | output | 1 | One-cycle pulse: STOP after data, start write |
| commit_wp | output | 1 | Protect level captured with the commit |

## Verification
On every cycle, the assertions check that acknowledge is only ever raised while SCL is low. They also check that no acknowledge follows a control byte taken while busy, and that the three event pulses never coincide. Two more checks are that a commit comes only from a detected STOP and that a START always returns the block to the control-byte state. Only the bench scenarios can show the rest. These are the decoding of all 256 control byte values, the assembly of the 15-bit address with its top bit dropped, and commit being held back after an address-only command. They also cover the silence after a mismatch or a busy NACK, the protect flag riding on the commit, and recovery after a repeated START.

// File: rtl/i2c_mem_write_slave.sv
module i2c_mem_write_slave #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [3:0]        dev_code,
  input  logic [2:0]        chip_sel,
  input  logic              wr_busy,
  input  logic              wp_in,
  output logic              sda_oe,
  output logic              addr_load,
  output logic [ADDR_W-1:0] addr_out,
  output logic              data_valid,
  output logic [7:0]        data_out,
  output logic              commit,
  output logic              commit_wp
);
  localparam int HI_W = ADDR_W - 8;

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_AHI, S_ALO, S_DATA} st_t;

  st_t             state;
  logic [1:0]      scl_sy, sda_sy;
  logic            scl_p, sda_p;
  logic [7:0]      shreg;
  logic [3:0]      bitcnt;
  logic [HI_W-1:0] addr_hi;
  logic            data_seen;

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire ctrl_ok   = (shreg[7:4] == dev_code) && (shreg[3:1] == chip_sel)
                   && !shreg[0] && !wr_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      shreg      <= '0;
      bitcnt     <= '0;
      addr_hi    <= '0;
      data_seen  <= 1'b0;
      sda_oe     <= 1'b0;
      addr_load  <= 1'b0;
      addr_out   <= '0;
      data_valid <= 1'b0;
      data_out   <= '0;
      commit     <= 1'b0;
      commit_wp  <= 1'b0;
    end else begin
      addr_load  <= 1'b0;
      data_valid <= 1'b0;
      commit     <= 1'b0;
      if (start_det) begin
        state     <= S_CTRL;
        bitcnt    <= '0;
        sda_oe    <= 1'b0;
        data_seen <= 1'b0;
      end else if (stop_det) begin
        state     <= S_IDLE;
        bitcnt    <= '0;
        sda_oe    <= 1'b0;
        data_seen <= 1'b0;
        if (data_seen) begin
          commit    <= 1'b1;
          commit_wp <= wp_in;
        end
      end else if (state != S_IDLE) begin
        if (scl_rise && bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          case (state)
            S_CTRL: begin
              if (ctrl_ok) begin
                sda_oe <= 1'b1;
                state  <= S_AHI;
              end else begin
                state  <= S_IDLE;
              end
            end
            S_AHI: begin
              sda_oe  <= 1'b1;
              addr_hi <= shreg[HI_W-1:0];
              state   <= S_ALO;
            end
            S_ALO: begin
              sda_oe    <= 1'b1;
              addr_out  <= {addr_hi, shreg};
              addr_load <= 1'b1;
              state     <= S_DATA;
            end
            default: begin
              sda_oe     <= 1'b1;
              data_out   <= shreg;
              data_valid <= 1'b1;
              data_seen  <= 1'b1;
            end
          endcase
        end else if (scl_fall && bitcnt == 4'd9) begin
          sda_oe <= 1'b0;
          bitcnt <= '0;
        end
      end
    end
  end

  // R3: acknowledge only ever starts while SCL is low
  a_r3_ack_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R7: a control byte taken while busy is never acknowledged
  a_r7_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && state == S_AHI) |-> !$past(wr_busy));

  // R6: commit only follows a detected STOP
  a_r6_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop_det));

  // R4/R5/R6: event pulses never coincide
  a_r5_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_load, data_valid, commit}));

  // R9: any START returns to control-byte state with the line released
  a_r9_start_resets: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == S_CTRL && !sda_oe));

  // R4: address pulse lands as the block enters the data phase
  a_r4_addr_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |-> state == S_DATA);
endmodule

// File: tb/test_i2c_mem_write_slave.sv
module test_i2c_mem_write_slave;
  localparam int Q = 5;

  logic clk = 0, rst_n = 0;
  logic scl = 1, sda_m = 1;
  logic [3:0] dev_code = 4'hA;
  logic [2:0] chip_sel = 3'd5;
  logic wr_busy = 0, wp_in = 0;
  logic sda_oe, addr_load, data_valid, commit, commit_wp;
  logic [14:0] addr_out;
  logic [7:0] data_out;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, failures = 0;
  int n_addr = 0, n_data = 0, n_commit = 0;
  logic [14:0] last_addr = '0;
  logic [7:0] dlog [0:15];
  logic last_wp = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  i2c_mem_write_slave i_i2c_mem_write_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .dev_code(dev_code), .chip_sel(chip_sel), .wr_busy(wr_busy), .wp_in(wp_in),
    .sda_oe(sda_oe), .addr_load(addr_load), .addr_out(addr_out),
    .data_valid(data_valid), .data_out(data_out),
    .commit(commit), .commit_wp(commit_wp));

  always @(negedge clk) begin
    if (addr_load) begin n_addr++; last_addr = addr_out; end
    if (data_valid) begin dlog[n_data % 16] = data_out; n_data++; end
    if (commit) begin n_commit++; last_wp = commit_wp; end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(posedge clk); #1; endtask

  task automatic bus_start();
    sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1; wq(); wq(); scl = 0; wq();
    end
    sda_m = 1; wq(); scl = 1; wq();
    acked = ~sda_line;
    wq(); scl = 0; wq();
  endtask

  logic a;
  int na, nd, nc;

  initial begin
    repeat (4) @(posedge clk); #1;
    rst_n = 1; wq();
    chk(sda_oe == 0 && addr_load == 0 && data_valid == 0 && commit == 0,
        "R3 reset idle", sda_oe, 0);

    // R2 sweep of every control byte value
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cb;
      logic exp;
      cb = 8'(c);
      exp = (cb[7:4] == 4'hA) && (cb[3:1] == 3'd5) && !cb[0];
      bus_start(); send_byte(cb, a); bus_stop();
      chk(a == exp, "R2 control decode", a, exp);
    end

    // R1/R3/R4/R5/R6 full write
    na = n_addr; nd = n_data; nc = n_commit;
    bus_start(); send_byte(8'hAA, a); chk(a, "R1 start and ctrl ack", a, 1);
    send_byte(8'hFF, a); chk(a, "R4 addr hi ack", a, 1);
    send_byte(8'h34, a); chk(a, "R4 addr lo ack", a, 1);
    chk(n_addr == na + 1 && last_addr == 15'h7F34, "R4 address msb dropped", last_addr, 15'h7F34);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'(8'h11 * (k + 1)), a);
      chk(a, "R5 data ack", a, 1);
      chk(dlog[(nd + k) % 16] == 8'(8'h11 * (k + 1)), "R5 data value",
          dlog[(nd + k) % 16], 8'h11 * (k + 1));
    end
    chk(n_data == nd + 3, "R5 data count", n_data - nd, 3);
    chk(n_commit == nc, "R6 no commit before stop", n_commit - nc, 0);
    bus_stop();
    chk(n_commit == nc + 1 && last_wp == 0, "R6 commit on stop", n_commit - nc, 1);

    // R8 protected write still acknowledged
    nc = n_commit; wp_in = 1;
    bus_start(); send_byte(8'hAA, a); chk(a, "R8 ctrl ack with protect", a, 1);
    send_byte(8'h00, a); send_byte(8'h40, a);
    send_byte(8'h5A, a); chk(a, "R8 data ack with protect", a, 1);
    bus_stop();
    chk(n_commit == nc + 1 && last_wp == 1, "R8 commit_wp set", last_wp, 1);
    wp_in = 0;

    // R6 stop after address only
    nc = n_commit;
    bus_start(); send_byte(8'hAA, a); send_byte(8'h01, a); send_byte(8'h02, a); bus_stop();
    chk(n_commit == nc, "R6 no commit without data", n_commit - nc, 0);

    // R7 busy NACK, then recovery
    wr_busy = 1; na = n_addr; nd = n_data;
    bus_start(); send_byte(8'hAA, a); chk(!a, "R7 busy nack", a, 0);
    send_byte(8'h12, a); chk(!a, "R7 rest ignored", a, 0);
    bus_stop(); wr_busy = 0;
    chk(n_addr == na && n_data == nd, "R7 no pulses while busy", n_addr - na, 0);
    bus_start(); send_byte(8'hAA, a); chk(a, "R7 ack after busy clears", a, 1); bus_stop();

    // R2 mismatch followed by silence
    na = n_addr;
    bus_start(); send_byte(8'hA0, a); chk(!a, "R2 mismatch nack", a, 0);
    send_byte(8'h12, a); chk(!a, "R2 ignored until start", a, 0);
    send_byte(8'h34, a); bus_stop();
    chk(n_addr == na, "R2 no address after mismatch", n_addr - na, 0);

    // R9 repeated start mid data
    na = n_addr; nc = n_commit;
    bus_start(); send_byte(8'hAA, a); send_byte(8'h00, a); send_byte(8'h10, a);
    send_byte(8'h55, a);
    bus_start(); send_byte(8'hAA, a); chk(a, "R9 ctrl after restart", a, 1);
    send_byte(8'h01, a); send_byte(8'h02, a);
    chk(n_addr == na + 2 && last_addr == 15'h0102, "R9 new address", last_addr, 15'h0102);
    bus_stop();
    chk(n_commit == nc, "R9 restart clears data", n_commit - nc, 0);

    // R9 stop mid address
    na = n_addr;
    bus_start(); send_byte(8'hAA, a); send_byte(8'h7E, a); bus_stop();
    bus_start(); send_byte(8'hAA, a); send_byte(8'h03, a); send_byte(8'h04, a); bus_stop();
    chk(n_addr == na + 1 && last_addr == 15'h0304, "R9 stop resets address", last_addr, 15'h0304);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule